// File: doc/BRIEF.md
# Two-Sided Inter-Processor Mailbox

This block lets two processors pass 32-bit words to each other through four slots in each direction. Each side sees its own small register window on a simple bus with address, write strobe, read strobe and data lines. Writing one of the side's four outgoing slots places a word in the matching incoming slot of the peer. A flag tells the peer a word is waiting. A second flag tells the sender when the word has been taken.

Each side has a status word with per-slot "outgoing empty" and "incoming full" flags. The slot order in this word is reversed, so slot 0 sits at the highest bit of each group. Each side also has a control word with three groups of four enables and a group of four general request bits. The enables cover general requests, incoming-full and outgoing-empty. The control word also has a 3-bit spare field. Each side has its own interrupt output, driven from its own flags and control word. Both sides share one clock and one reset.

Top module: `mbox_unit`

## Requirements
- R1: After reset each side's status reads 0x00F00000 (all outgoing-empty flags 1, all incoming-full flags 0), its control reads 0, and both interrupt outputs are 0.
- R2: The word address map per side is: 0..3 outgoing slots (write), 4..7 incoming slots (read), 8 status, 9 control. A read returns data on `*_rdata` in the cycle after the read strobe. Reading an address 0..3 or 10..15 returns 0.
- R3: A write to outgoing slot n clears the writer's status bit 23-n and sets the peer's status bit 27-n, visible from the next cycle.
- R4: A read of incoming slot n returns the last word the peer wrote to its slot n. It clears the reader's status bit 27-n and sets the peer's status bit 23-n from the next cycle.
- R5: Writing an outgoing slot that is still full replaces the pending word. The flags stay as after a single write, and no other status bit is set.
- R6: If the sender writes slot n in the same cycle the receiver reads slot n, the read returns the earlier word and the full flag stays set. A later read returns the new word.
- R7: Control bits 31:16 and 2:0 are writable. All other control bits read 0. Writing 0 clears all enables, requests and the spare field at once.
- R8: Control bit 27-n enables incoming-full n, bit 23-n enables outgoing-empty n, and bit 31-n enables general request bit 19-n. The interrupt is registered and equals the OR over all enabled terms of the previous cycle's flags and control, so it follows a control write by one extra cycle.
- R9: Bus writes to addresses 4..8 have no effect on any flag, control bit or interrupt.
- R10: The two directions are independent: the slots and flags of one direction are not changed by traffic in the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| a_addr | input | 4 | Side A word address |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, valid the cycle after `a_rd` |
| a_irq | output | 1 | Side A interrupt |
| b_addr | input | 4 | Side B word address |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, valid the cycle after `b_rd` |
| b_irq | output | 1 | Side B interrupt |

## Verification
The hardest case to reach is a collision on one slot: the sender writes it in the same cycle the receiver reads it. Ordinary one-side-at-a-time tasks cannot produce it. The bench therefore drives both sides' strobes in one hand-built cycle and then checks the returned word, the flags and the follow-up read. The interrupt sweep first parks known words in some slots so that full and empty flags both exist. It then steps single enable bits, and matched and mismatched request and enable pairs, through each side's control word.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Slot count is fixed at four: the status and control layouts depend on it.
  localparam int SLOTS  = 4;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_STAT = 4'd8;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd9;

  // Highest bit of each slot-reversed group; slot n sits at HI-n.
  localparam int TE_HI  = 23;
  localparam int RF_HI  = 27;
  localparam int TIE_HI = 23;
  localparam int RIE_HI = 27;
  localparam int GIE_HI = 31;
  localparam int GIR_HI = 19;

  localparam logic [31:0] CTRL_MASK = 32'hFFFF_0007;
  localparam logic [31:0] STAT_USED = 32'h0FF0_0000;

  typedef enum logic [1:0] {RS_NONE, RS_SLOT, RS_REG} rsel_t;
endpackage

// File: rtl/mbox_slot_bank.sv
module mbox_slot_bank
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SLOT_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [SLOT_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata_q,
  output logic [SLOTS-1:0]  full
);
  // Storage written and read synchronously so it maps onto RAM.
  logic [DATA_W-1:0] mem [SLOTS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_q <= mem[raddr];
  end

  // Per-slot full flag: a write sets it and wins over a read that clears it.
  for (genvar n = 0; n < SLOTS; n++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                                full[n] <= 1'b0;
      else if (we && waddr == SLOT_W'(n))     full[n] <= 1'b1;
      else if (re && raddr == SLOT_W'(n))     full[n] <= 1'b0;
    end
  end

  // R3
  write_sets_full_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> full[$past(waddr)]);

  // R4
  read_clears_full_chk: assert property (@(posedge clk) disable iff (rst)
    (re && !(we && waddr == raddr)) |=> !full[$past(raddr)]);

  // R6
  collide_keeps_full_chk: assert property (@(posedge clk) disable iff (rst)
    (re && we && waddr == raddr) |=> full[$past(raddr)]);
endmodule

// File: rtl/mbox_port.sv
module mbox_port
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SLOTS-1:0]  tx_full,
  input  logic [SLOTS-1:0]  rx_full,
  input  logic [DATA_W-1:0] rx_word,
  output logic              tx_we,
  output logic [SLOT_W-1:0] tx_idx,
  output logic              rx_re,
  output logic [SLOT_W-1:0] rx_idx,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int HI_W = ADDR_W - SLOT_W;

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] reg_q;
  logic [DATA_W-1:0] stat;
  rsel_t             rsel_q;
  logic              irq_q;
  logic [SLOTS-1:0]  hit;
  logic              tx_sel, rx_sel;

  assign tx_sel = (addr[ADDR_W-1:SLOT_W] == HI_W'(0));
  assign rx_sel = (addr[ADDR_W-1:SLOT_W] == HI_W'(1));
  assign tx_we  = wr && tx_sel;
  assign tx_idx = addr[SLOT_W-1:0];
  assign rx_re  = rd && rx_sel;
  assign rx_idx = addr[SLOT_W-1:0];

  // Status word with slot-reversed flag groups.
  always_comb begin
    stat = '0;
    for (int n = 0; n < SLOTS; n++) begin
      stat[TE_HI-n] = ~tx_full[n];
      stat[RF_HI-n] = rx_full[n];
    end
  end

  // Per-slot interrupt terms.
  always_comb begin
    for (int n = 0; n < SLOTS; n++) begin
      hit[n] = (rx_full[n]  & ctrl_q[RIE_HI-n])
             | (~tx_full[n] & ctrl_q[TIE_HI-n])
             | (ctrl_q[GIR_HI-n] & ctrl_q[GIE_HI-n]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      reg_q  <= '0;
      rsel_q <= RS_NONE;
      irq_q  <= 1'b0;
    end else begin
      if (wr && addr == A_CTRL) ctrl_q <= wdata & CTRL_MASK;
      irq_q <= |hit;
      if (rd) begin
        if (rx_sel) begin
          rsel_q <= RS_SLOT;
        end else if (addr == A_STAT) begin
          rsel_q <= RS_REG;
          reg_q  <= stat;
        end else if (addr == A_CTRL) begin
          rsel_q <= RS_REG;
          reg_q  <= ctrl_q;
        end else begin
          rsel_q <= RS_NONE;
        end
      end
    end
  end

  always_comb begin
    case (rsel_q)
      RS_SLOT: rdata = rx_word;
      RS_REG:  rdata = reg_q;
      default: rdata = '0;
    endcase
  end

  assign irq = irq_q;

  // R7
  ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_CTRL) |=> (ctrl_q == ($past(wdata) & CTRL_MASK)));

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_q[31:20]) == 12'h000) |-> !irq);

  // R2
  stat_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == A_STAT) |=> ((rdata & ~STAT_USED) == '0));

  // R9
  ro_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && !tx_sel && addr != A_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/mbox_unit.sv
module mbox_unit
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_irq,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_irq
);
  // Bank 0 carries A -> B, bank 1 carries B -> A.
  logic              we   [2];
  logic [SLOT_W-1:0] widx [2];
  logic              re   [2];
  logic [SLOT_W-1:0] ridx [2];
  logic [DATA_W-1:0] word [2];
  logic [SLOTS-1:0]  full [2];

  mbox_slot_bank #(.DATA_W(DATA_W)) u_bank_ab (
    .clk(clk), .rst(rst),
    .we(we[0]), .waddr(widx[0]), .wdata(a_wdata),
    .re(re[1]), .raddr(ridx[1]),
    .rdata_q(word[0]), .full(full[0])
  );

  mbox_slot_bank #(.DATA_W(DATA_W)) u_bank_ba (
    .clk(clk), .rst(rst),
    .we(we[1]), .waddr(widx[1]), .wdata(b_wdata),
    .re(re[0]), .raddr(ridx[0]),
    .rdata_q(word[1]), .full(full[1])
  );

  mbox_port #(.DATA_W(DATA_W)) u_port_a (
    .clk(clk), .rst(rst),
    .addr(a_addr), .wr(a_wr), .rd(a_rd), .wdata(a_wdata),
    .tx_full(full[0]), .rx_full(full[1]), .rx_word(word[1]),
    .tx_we(we[0]), .tx_idx(widx[0]), .rx_re(re[0]), .rx_idx(ridx[0]),
    .rdata(a_rdata), .irq(a_irq)
  );

  mbox_port #(.DATA_W(DATA_W)) u_port_b (
    .clk(clk), .rst(rst),
    .addr(b_addr), .wr(b_wr), .rd(b_rd), .wdata(b_wdata),
    .tx_full(full[1]), .rx_full(full[0]), .rx_word(word[0]),
    .tx_we(we[1]), .tx_idx(widx[1]), .rx_re(re[1]), .rx_idx(ridx[1]),
    .rdata(b_rdata), .irq(b_irq)
  );

  // R10
  a_side_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    (!a_wr && !b_rd) |=> $stable(full[0]));
endmodule

// File: tb/mbox_unit_tb_top.sv
module mbox_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MASK = 32'hFFFF_0007;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0]  adr [2];
  logic        wr  [2];
  logic        rd  [2];
  logic [31:0] wd  [2];
  logic [31:0] rdv [2];
  logic        irqv[2];

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic [31:0] m_data [2][4];
  bit          m_full [2][4];
  logic [31:0] m_ctrl [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_unit dut_i (
    .clk(clk), .rst(rst),
    .a_addr(adr[0]), .a_wr(wr[0]), .a_rd(rd[0]), .a_wdata(wd[0]),
    .a_rdata(rdv[0]), .a_irq(irqv[0]),
    .b_addr(adr[1]), .b_wr(wr[1]), .b_rd(rd[1]), .b_wdata(wd[1]),
    .b_rdata(rdv[1]), .b_irq(irqv[1])
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat(int s);
    logic [31:0] r = '0;
    for (int n = 0; n < 4; n++) begin
      if (!m_full[s][n])  r[23-n] = 1'b1;
      if (m_full[1-s][n]) r[27-n] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic exp_irq(int s);
    logic r = 1'b0;
    logic [31:0] c = m_ctrl[s];
    for (int n = 0; n < 4; n++) begin
      if (m_full[1-s][n] && c[27-n]) r = 1'b1;
      if (!m_full[s][n] && c[23-n])  r = 1'b1;
      if (c[19-n] && c[31-n])        r = 1'b1;
    end
    return r;
  endfunction

  task automatic wr_op(int s, logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    adr[s] = a; wd[s] = d; wr[s] = 1'b1;
    @(negedge clk);
    wr[s] = 1'b0;
    if (a < 4) begin
      m_data[s][a] = d;
      m_full[s][a] = 1'b1;
    end else if (a == 4'd9) begin
      m_ctrl[s] = d & MASK;
    end
  endtask

  task automatic rd_op(int s, logic [3:0] a, output logic [31:0] q);
    @(negedge clk);
    adr[s] = a; rd[s] = 1'b1;
    @(negedge clk);
    rd[s] = 1'b0;
    q = rdv[s];
    if (a >= 4 && a < 8) m_full[1-s][a-4] = 1'b0;
  endtask

  task automatic chk_state(string tag);
    logic [31:0] q;
    for (int s = 0; s < 2; s++) begin
      rd_op(s, 4'd8, q);
      check(tag, q, exp_stat(s));
    end
  endtask

  task automatic chk_irq(string tag);
    @(negedge clk);
    check({tag, " irqA"}, {31'b0, irqv[0]}, {31'b0, exp_irq(0)});
    check({tag, " irqB"}, {31'b0, irqv[1]}, {31'b0, exp_irq(1)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    logic [31:0] d;
    for (int s = 0; s < 2; s++) begin
      adr[s] = '0; wr[s] = 1'b0; rd[s] = 1'b0; wd[s] = '0;
      m_ctrl[s] = '0;
      for (int n = 0; n < 4; n++) begin
        m_full[s][n] = 1'b0; m_data[s][n] = '0;
      end
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk_state("R1 status");
    for (int s = 0; s < 2; s++) begin
      rd_op(s, 4'd9, q);
      check("R1 control", q, 32'h0);
    end
    chk_irq("R1");

    // R3 / R4 sweep of every slot, side and pattern
    for (int s = 0; s < 2; s++)
      for (int n = 0; n < 4; n++)
        for (int p = 0; p < 3; p++) begin
          d = 32'hA500_0000 ^ (s << 16) ^ (n << 8) ^ (p * 32'h0101_0101);
          if (p == 2) d = ~d;
          wr_op(s, 4'(n), d);
          chk_state("R3 flags after write");
          rd_op(1 - s, 4'(4 + n), q);
          check("R4 data", q, m_data[s][n]);
          chk_state("R4 flags after read");
        end

    // R10 both directions full at once
    for (int s = 0; s < 2; s++)
      for (int n = 0; n < 4; n++)
        wr_op(s, 4'(n), 32'h1000_0000 * (s + 1) + n * 32'h111);
    chk_state("R10 all full");
    for (int n = 0; n < 4; n++) begin
      rd_op(1, 4'(4 + n), q);
      check("R10 A to B data", q, m_data[0][n]);
    end
    chk_state("R10 one direction drained");
    for (int n = 0; n < 4; n++) begin
      rd_op(0, 4'(4 + n), q);
      check("R10 B to A data", q, m_data[1][n]);
    end
    chk_state("R10 both drained");

    // R5 overwrite
    wr_op(0, 4'd2, 32'hDEAD_0001);
    wr_op(0, 4'd2, 32'hBEEF_0002);
    chk_state("R5 flags after overwrite");
    rd_op(1, 4'd6, q);
    check("R5 data", q, 32'hBEEF_0002);
    chk_state("R5 drained");

    // R6 collision
    wr_op(0, 4'd1, 32'h0000_AAAA);
    @(negedge clk);
    adr[0] = 4'd1; wd[0] = 32'h0000_BBBB; wr[0] = 1'b1;
    adr[1] = 4'd5; rd[1] = 1'b1;
    @(negedge clk);
    wr[0] = 1'b0; rd[1] = 1'b0;
    check("R6 old word", rdv[1], 32'h0000_AAAA);
    m_data[0][1] = 32'h0000_BBBB;
    m_full[0][1] = 1'b1;
    chk_state("R6 full kept");
    rd_op(1, 4'd5, q);
    check("R6 new word", q, 32'h0000_BBBB);
    chk_state("R6 drained");

    // R7 control field mask
    for (int s = 0; s < 2; s++) begin
      wr_op(s, 4'd9, 32'hFFFF_FFFF);
      rd_op(s, 4'd9, q);
      check("R7 all ones", q, 32'hFFFF_0007);
      wr_op(s, 4'd9, 32'h1234_5675);
      rd_op(s, 4'd9, q);
      check("R7 pattern", q, 32'h1234_0005);
      wr_op(s, 4'd9, 32'h0);
      rd_op(s, 4'd9, q);
      check("R7 clear", q, 32'h0);
    end

    // R2 unmapped reads
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 4; a++) begin
        rd_op(s, 4'(a), q);
        check("R2 outgoing slot read", q, 32'h0);
      end
      for (int a = 10; a < 16; a++) begin
        rd_op(s, 4'(a), q);
        check("R2 unmapped read", q, 32'h0);
      end
    end

    // R8 interrupt sweep with slots 0 and 2 of A to B full
    wr_op(0, 4'd0, 32'h5);
    wr_op(0, 4'd2, 32'h6);
    for (int s = 0; s < 2; s++) begin
      for (int k = 16; k < 32; k++) begin
        wr_op(s, 4'd9, 32'h1 << k);
        chk_irq("R8 single bit");
      end
      for (int n = 0; n < 4; n++) begin
        wr_op(s, 4'd9, (32'h1 << (19 - n)) | (32'h1 << (31 - n)));
        chk_irq("R8 matched request");
        wr_op(s, 4'd9, (32'h1 << (19 - n)) | (32'h1 << (31 - ((n + 1) % 4))));
        chk_irq("R8 mismatched request");
      end
      wr_op(s, 4'd9, 32'h0);
      chk_irq("R8 cleared");
    end

    // R9 writes to read-only addresses
    wr_op(0, 4'd9, 32'h0F00_0000);
    for (int s = 0; s < 2; s++)
      for (int a = 4; a < 9; a++)
        wr_op(s, 4'(a), 32'hFFFF_FFFF);
    chk_state("R9 flags unchanged");
    rd_op(0, 4'd9, q);
    check("R9 control unchanged", q, 32'h0F00_0000);
    chk_irq("R9");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule